// File: doc/BRIEF.md
# Frame Sequencer with Electronic Shutter

This block sequences the frames of an area image sensor that has a light-sensitive image zone and a shielded storage zone. Each frame starts with a fast shift of the whole image into the storage zone. The storage zone is then read out line by line. The readout interval also serves as the exposure time of the following image. The block starts the vertical shift generator with a one-cycle pulse and waits for its completion strobe. It then asks a line sequencer for one line at a time, and each request waits for that line's completion strobe.

When the shutter is enabled, the block shortens the exposure. After readout it holds all four image-zone phases low, which drains photocharge into the overflow drain. It releases them a programmed number of cycles before the next transfer. Two values are sampled while idle and at each frame start: the exposure length and the frame period, both in clock cycles. The exposure is clamped so that it fits the frame, and it never falls below a minimum settling gap.

A cleaning pass sweeps the storage zone with the same line requests as a readout, with the data marked as discarded. A binning flag is captured at each frame start and handed to the line sequencer, and binned frames use half as many lines.

Top module: `frame_shutter_ctrl`

## Requirements
- R1: While reset is held and while the block is idle after reset, frame_start_o, line_start_o, drain_o, discard_o and bin_o are all low.
- R2: frame_start_o is a one-cycle pulse issued on the first cycle of each image-to-storage transfer. The transfer ends in the cycle xfer_done_i is high, and storage readout begins in the next cycle.
- R3: A readout issues LINES one-cycle line_start_o pulses, or LINES/2 when the binning flag captured at that frame start is 1. The first pulse comes in the first readout cycle, and each later pulse comes in the cycle after the previous line's line_done_i.
- R4: While run_i stays high and readout finishes in time, successive frame_start_o pulses are exactly frame_cyc_i cycles apart.
- R5: With shutter_en_i high, drain_o is high from the end of readout until the effective exposure E begins. The last cycle with drain_o high lies exactly E+1 cycles before the next frame_start_o.
- R6: The effective exposure E is expo_cyc_i limited to frame_cyc_i minus XFER_CYC (zero if that difference would be negative), and then raised to at least GAP_CYC.
- R7: With shutter_en_i low, drain_o never goes high.
- R8: If readout ends later than the frame period allows, frame_start_o follows two cycles after the cycle that carries the last line_done_i.
- R9: clean_i in the idle state has priority over run_i. It starts a cleaning pass of LINES line_start_o pulses with discard_o high, and no frame_start_o is issued. The block then returns to idle.
- R10: When run_i is low at the end of a readout, or falls during drain or integration, no further frame_start_o is issued.
- R11: bin_o takes the value of bin_i only on a frame_start_o cycle and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Keep producing frames while high |
| clean_i | input | 1 | Request a storage-zone cleaning pass (idle only) |
| shutter_en_i | input | 1 | Enable the drain interval that shortens exposure |
| bin_i | input | 1 | Binning request, captured at frame start |
| expo_cyc_i | input | CW | Requested exposure length in cycles |
| frame_cyc_i | input | CW | Frame period in cycles |
| frame_start_o | output | 1 | One-cycle pulse starting the vertical shift generator |
| xfer_done_i | input | 1 | Vertical shift generator finished |
| line_start_o | output | 1 | One-cycle request to the line sequencer |
| line_done_i | input | 1 | Line sequencer finished the current line |
| discard_o | output | 1 | Lines being read belong to a cleaning pass |
| drain_o | output | 1 | Hold all four image-zone phases low |
| bin_o | output | 1 | Binning flag for the frame in progress |

## Verification
The hardest situation to reach is a readout that overruns the frame period. In that case the timer has already passed its limit when the last line completes, and the transfer must follow after a single integration cycle. The bench gets there by making its line sequencer model answer each request 30 cycles late, which stretches readout to several times a short frame period. The exposure clamp at both bounds is reached by programming an exposure larger than the frame period and one smaller than the settling gap. The bench then measures where the drain interval ends with respect to each frame pulse.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAN,
    ST_DRAIN,
    ST_INTEG,
    ST_XFER,
    ST_READ
  } fsc_state_e;

  // Exposure actually used: fit inside the frame, never shorter than the gap.
  function automatic int unsigned fsc_expo_limit(int unsigned expo, int unsigned frame,
                                                 int unsigned xfer, int unsigned gap);
    int unsigned ceiling;
    int unsigned eff;
    ceiling = (frame > xfer) ? frame - xfer : 0;
    eff     = (expo < ceiling) ? expo : ceiling;
    if (eff < gap) eff = gap;
    return eff;
  endfunction

  // Lines per readout pass.
  function automatic int unsigned fsc_line_total(int unsigned lines, logic binned);
    return binned ? lines / 2 : lines;
  endfunction

  // Drain stays open while the upcoming cycle lies before the exposure window.
  function automatic logic fsc_drain_open(longint unsigned cnt_next, longint unsigned expo,
                                          longint unsigned frame);
    return (cnt_next + expo) < frame;
  endfunction

  // The frame period has elapsed once the upcoming count reaches it.
  function automatic logic fsc_frame_due(longint unsigned cnt_next, longint unsigned frame);
    return cnt_next >= frame;
  endfunction

endpackage

// File: rtl/fsc_frame_timer.sv
module fsc_frame_timer #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fsc_line_stepper.sv
module fsc_line_stepper #(
  parameter int unsigned LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [LW-1:0] total_i,
  input  logic          done_i,
  output logic          start_o,
  output logic          last_o
);
  logic          busy_q;
  logic          start_q;
  logic [LW-1:0] idx_q;
  logic [LW-1:0] total_q;
  logic          at_end;

  assign at_end = (idx_q == total_q - LW'(1));
  assign last_o = busy_q & done_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      idx_q   <= '0;
      total_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (go_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        total_q <= total_i;
        start_q <= 1'b1;
      end else if (busy_q && done_i) begin
        if (at_end) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/frame_shutter_ctrl.sv
module frame_shutter_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned LINES    = 1044,
  parameter int unsigned CW       = 24,
  parameter int unsigned XFER_CYC = 167040,
  parameter int unsigned GAP_CYC  = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clean_i,
  input  logic          shutter_en_i,
  input  logic          bin_i,
  input  logic [CW-1:0] expo_cyc_i,
  input  logic [CW-1:0] frame_cyc_i,
  output logic          frame_start_o,
  input  logic          xfer_done_i,
  output logic          line_start_o,
  input  logic          line_done_i,
  output logic          discard_o,
  output logic          drain_o,
  output logic          bin_o
);
  localparam int unsigned LW = $clog2(LINES + 1);

  fsc_state_e    state_q, state_d;
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_nx;
  logic [CW-1:0] f_lat, e_lat, f_use, e_use, e_in;
  logic          fs_q, bin_q;

  // Named internal events
  logic          enter_xfer, enter_read, enter_clean;
  logic          line_go, line_last;
  logic          drain_nx, idle_drain, frame_due, clr_timer;
  logic [LW-1:0] line_total;

  assign e_in  = CW'(fsc_expo_limit(32'(expo_cyc_i), 32'(frame_cyc_i), XFER_CYC, GAP_CYC));
  assign f_use = (state_q == ST_IDLE) ? frame_cyc_i : f_lat;
  assign e_use = (state_q == ST_IDLE) ? e_in : e_lat;

  assign cnt_nx     = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign drain_nx   = fsc_drain_open(64'(cnt_nx), 64'(e_use), 64'(f_use));
  assign idle_drain = fsc_drain_open(64'd0, 64'(e_use), 64'(f_use));
  assign frame_due  = fsc_frame_due(64'(cnt_nx), 64'(f_use));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (clean_i)    state_d = ST_CLEAN;
        else if (run_i) state_d = (shutter_en_i && idle_drain) ? ST_DRAIN : ST_INTEG;
      end
      ST_CLEAN: begin
        if (line_last) state_d = ST_IDLE;
      end
      ST_DRAIN: begin
        if (!run_i)         state_d = ST_IDLE;
        else if (!drain_nx) state_d = ST_INTEG;
      end
      ST_INTEG: begin
        if (!run_i)         state_d = ST_IDLE;
        else if (frame_due) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (xfer_done_i) state_d = ST_READ;
      end
      ST_READ: begin
        if (line_last) begin
          if (!run_i)                         state_d = ST_IDLE;
          else if (shutter_en_i && drain_nx)  state_d = ST_DRAIN;
          else                                state_d = ST_INTEG;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_xfer  = (state_d == ST_XFER)  && (state_q != ST_XFER);
  assign enter_read  = (state_d == ST_READ)  && (state_q != ST_READ);
  assign enter_clean = (state_d == ST_CLEAN) && (state_q != ST_CLEAN);
  assign line_go     = enter_read | enter_clean;
  assign line_total  = LW'(fsc_line_total(LINES, enter_clean ? 1'b0 : bin_q));
  assign clr_timer   = (state_q == ST_IDLE) | enter_xfer;

  fsc_frame_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_timer),
    .cnt_o (cnt)
  );

  fsc_line_stepper #(.LW(LW)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (line_go),
    .total_i (line_total),
    .done_i  (line_done_i),
    .start_o (line_start_o),
    .last_o  (line_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      f_lat   <= '0;
      e_lat   <= '0;
      fs_q    <= 1'b0;
      bin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fs_q    <= enter_xfer;
      if (state_q == ST_IDLE || enter_xfer) begin
        f_lat <= frame_cyc_i;
        e_lat <= e_in;
      end
      if (enter_xfer) bin_q <= bin_i;
    end
  end

  assign frame_start_o = fs_q;
  assign drain_o       = (state_q == ST_DRAIN);
  assign discard_o     = (state_q == ST_CLEAN);
  assign bin_o         = bin_q;
endmodule

// File: rtl/fsc_frame_ctrl_chk.sv
module fsc_frame_ctrl_chk #(
  parameter int unsigned GAP_CYC = 200
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start_o,
  input logic line_start_o,
  input logic discard_o,
  input logic drain_o,
  input logic bin_o,
  input logic enter_xfer
);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_CYC + 1);

  logic [GW-1:0] since_drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_drain <= GAP_SAT;
    else if (drain_o)              since_drain <= '0;
    else if (since_drain != GAP_SAT) since_drain <= since_drain + 1'b1;
  end

  AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R2
  AST_FRAME_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_xfer |=> frame_start_o); // R2
  AST_LINE_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> !line_start_o); // R3
  AST_DRAIN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (!drain_o && since_drain >= GW'(GAP_CYC))); // R5
  AST_CLEAN_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> !frame_start_o); // R9
  AST_BIN_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bin_o) |-> frame_start_o); // R11
endmodule

bind frame_shutter_ctrl fsc_frame_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_fsc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_o (frame_start_o),
  .line_start_o  (line_start_o),
  .discard_o     (discard_o),
  .drain_o       (drain_o),
  .bin_o         (bin_o),
  .enter_xfer    (enter_xfer)
);

// File: tb/test_frame_shutter_ctrl.sv
`timescale 1ns/1ps
module test_frame_shutter_ctrl;
  localparam int LN = 12;
  localparam int CWB = 16;
  localparam int XF = 60;
  localparam int GP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 0, clean_i = 0, shutter_en_i = 0, bin_i = 0;
  logic [CWB-1:0] expo_cyc_i = '0, frame_cyc_i = '0;
  logic xfer_done_i = 0, line_done_i = 0;
  logic frame_start_o, line_start_o, discard_o, drain_o, bin_o;

  always #2.5 clk = ~clk;

  frame_shutter_ctrl #(.LINES(LN), .CW(CWB), .XFER_CYC(XF), .GAP_CYC(GP)) i_frame_shutter_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .clean_i(clean_i), .shutter_en_i(shutter_en_i),
    .bin_i(bin_i), .expo_cyc_i(expo_cyc_i), .frame_cyc_i(frame_cyc_i),
    .frame_start_o(frame_start_o), .xfer_done_i(xfer_done_i), .line_start_o(line_start_o),
    .line_done_i(line_done_i), .discard_o(discard_o), .drain_o(drain_o), .bin_o(bin_o));

  int errors = 0, checks = 0, cyc = 0;
  bit fin = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int expo_of(int e, int f);
    int room, r;
    room = f - XF;
    if (room < 0) room = 0;
    r = e;
    if (r > room) r = room;
    if (r < GP) r = GP;
    return r;
  endfunction

  // ---------------- behavioural reference ----------------
  // phases: 0 idle, 1 clean, 2 drain, 3 integrate, 4 transfer, 5 readout
  int m_ph = 0, m_t = 0, m_left = 0;
  bit m_fs = 0, m_ls = 0, m_bin = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_left = 0; m_fs = 0; m_ls = 0; m_bin = 0;
    end else begin
      int f, e, nph, nt;
      bit nfs, nls;
      f = int'(frame_cyc_i);
      e = expo_of(int'(expo_cyc_i), f);
      nph = m_ph; nt = m_t + 1; nfs = 0; nls = 0;
      case (m_ph)
        0: begin
          nt = 0;
          if (clean_i) begin nph = 1; m_left = LN; nls = 1; end
          else if (run_i) nph = (shutter_en_i && e < f) ? 2 : 3;
        end
        2: if (!run_i) nph = 0; else if (m_t + 1 + e >= f) nph = 3;
        3: if (!run_i) nph = 0;
           else if (m_t + 1 >= f) begin nph = 4; nt = 0; nfs = 1; m_bin = bin_i; end
        4: if (xfer_done_i) begin nph = 5; m_left = m_bin ? LN / 2 : LN; nls = 1; end
        default: if (line_done_i) begin
          m_left--;
          if (m_left > 0) nls = 1;
          else if (m_ph == 1 || !run_i) nph = 0;
          else nph = (shutter_en_i && (m_t + 1 + e < f)) ? 2 : 3;
        end
      endcase
      m_ph = nph; m_t = nt; m_fs = nfs; m_ls = nls;
    end
  end

  always @(posedge clk) cyc++;

  // per-cycle comparison
  initial forever begin
    @(negedge clk);
    checks++;
    if (frame_start_o !== m_fs || line_start_o !== m_ls || drain_o !== (m_ph == 2) ||
        discard_o !== (m_ph == 1) || bin_o !== m_bin) begin
      errors++;
      if (frame_start_o !== m_fs)
        $display("FAIL R2: frame_start actual=%0b expected=%0b (cycle %0d)", frame_start_o, m_fs, cyc);
      if (line_start_o !== m_ls)
        $display("FAIL R3: line_start actual=%0b expected=%0b (cycle %0d)", line_start_o, m_ls, cyc);
      if (drain_o !== (m_ph == 2))
        $display("FAIL R5: drain actual=%0b expected=%0b (cycle %0d)", drain_o, m_ph == 2, cyc);
      if (discard_o !== (m_ph == 1))
        $display("FAIL R9: discard actual=%0b expected=%0b (cycle %0d)", discard_o, m_ph == 1, cyc);
      if (bin_o !== m_bin)
        $display("FAIL R11: bin actual=%0b expected=%0b (cycle %0d)", bin_o, m_bin, cyc);
    end
  end

  // ---------------- responders ----------------
  int line_lat = 2, xc = 0, lc = 0, ld_cyc = -100;
  initial forever begin
    @(negedge clk);
    xfer_done_i = 0; line_done_i = 0;
    if (xc > 0) begin xc--; if (xc == 0) xfer_done_i = 1; end
    if (frame_start_o) xc = 2;
    if (lc > 0) begin lc--; if (lc == 0) begin line_done_i = 1; ld_cyc = cyc; end end
    if (line_start_o) lc = line_lat;
  end

  // ---------------- frame monitor ----------------
  int fs_total = 0, ls_total = 0, ls_frame = 0, drain_total = 0, gapc = 100000, prev_fs = -1;
  int exp_period = 0, exp_gap = 0, exp_lines = 0;
  bit chk_over = 0;
  string gap_tag = "R5";
  initial forever begin
    @(negedge clk);
    if (line_start_o) begin ls_total++; ls_frame++; end
    if (drain_o) begin drain_total++; gapc = 0; end else gapc++;
    if (frame_start_o) begin
      fs_total++;
      if (prev_fs >= 0) begin
        if (exp_period > 0) check("R4", cyc - prev_fs, exp_period);
        if (exp_lines > 0) check("R3", ls_frame, exp_lines);
        if (chk_over) check("R8", cyc - ld_cyc, 2);
      end
      if (exp_gap > 0) check(gap_tag, gapc, exp_gap);
      ls_frame = 0;
      prev_fs = cyc;
    end
  end

  task automatic run_frames(bit shut, bit bn, int e, int f, int ld, int n, int period,
                            int gap, string gtag, int lines, bit over, bit probe);
    int tgt, f0;
    @(negedge clk);
    shutter_en_i = shut; bin_i = bn; expo_cyc_i = CWB'(e); frame_cyc_i = CWB'(f);
    line_lat = ld; exp_period = period; exp_gap = gap; gap_tag = gtag;
    exp_lines = lines; chk_over = over; prev_fs = -1; ls_frame = 0;
    run_i = 1;
    if (probe) begin
      tgt = fs_total + 1;
      do @(negedge clk); while (fs_total < tgt);
      repeat (60) @(negedge clk);
      bin_i = 1;
      repeat (50) begin @(negedge clk); check("R11", bin_o, 0); end
      bin_i = 0;
    end
    tgt = fs_total + n;
    do @(negedge clk); while (fs_total < tgt);
    run_i = 0;
    f0 = fs_total;
    repeat (1500) @(negedge clk);
    check("R10", fs_total, f0);
    exp_period = 0; exp_gap = 0; exp_lines = 0; chk_over = 0;
  endtask

  initial begin
    int d0, l0, f0;
    repeat (3) begin
      @(negedge clk);
      check("R1", {frame_start_o, line_start_o, drain_o, discard_o, bin_o}, 0);
    end
    rst_n = 1;
    repeat (5) begin
      @(negedge clk);
      check("R1", {frame_start_o, line_start_o, drain_o, discard_o, bin_o}, 0);
    end
    // R4 R5 R3 R11: nominal shuttered frames, bin probe mid-frame
    run_frames(1, 0, 30, 200, 2, 4, 200, 31, "R5", LN, 0, 1);
    // R6: exposure above the frame room, then below the gap
    run_frames(1, 0, 500, 200, 2, 3, 200, 141, "R6", LN, 0, 0);
    run_frames(1, 0, 1, 200, 2, 3, 200, GP + 1, "R6", LN, 0, 0);
    // R7: shutter off
    d0 = drain_total;
    run_frames(0, 0, 30, 150, 2, 3, 150, 0, "R5", LN, 0, 0);
    check("R7", drain_total, d0);
    // R3: binned frames use half the lines
    run_frames(1, 1, 30, 200, 2, 3, 200, 31, "R5", LN / 2, 0, 0);
    check("R11", bin_o, 1);
    // R8: readout overruns a short frame period
    run_frames(0, 0, 30, 100, 30, 3, 0, 0, "R5", LN, 1, 0);
    // R9: cleaning pass wins over run
    l0 = ls_total; f0 = fs_total;
    @(negedge clk); clean_i = 1; run_i = 1; line_lat = 2;
    @(negedge clk); clean_i = 0; run_i = 0;
    repeat (200) @(negedge clk);
    check("R9", ls_total - l0, LN);
    check("R9", fs_total, f0);
    check("R1", {frame_start_o, line_start_o, drain_o, discard_o}, 0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R4: watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule